// File: doc/BRIEF.md
# Serial ADC Command Interface Slave

This block is the digital serial-port half of an eight-channel, 12-bit sampling converter. A host, acting as bus master, pulls the active-low chip select low and toggles the serial clock. On each rising serial-clock edge it presents one data bit. The block skips any leading zeros. It treats the first 1 as the start of an eight-bit command, and decodes the channel, polarity, input-mode and power/clock-mode fields from it. The analog side is replaced by a parallel bus with one 12-bit sample per channel.

When the command selects external-clock conversion, the block latches the chosen sample and pulses a strobe for one serial-clock period. It then shifts the result out MSB first on the falling serial-clock edges. Power-down and internal-clock commands are only decoded and reported on the command outputs; they produce no serial result. The serial pins are treated as synchronous to the system clock `clk`. Serial-clock edges are detected by comparing each serial-clock level with the previous one.

The state machine has seven states:
- `ST_IDLE`: chip select high.
- `ST_HUNT`: searching for the start bit.
- `ST_CMD`: collecting the seven command bits after the start bit.
- `ST_ARM`: waiting for the falling edge that raises the strobe.
- `ST_STRB`: strobe period.
- `ST_SHIFT`: result bits on the output.
- `ST_HOLD`: frame finished, waiting for chip select to rise.

Transitions:
- Chip select high takes every state to `ST_IDLE`.
- `ST_IDLE` goes to `ST_HUNT` once chip select is low, or straight to `ST_CMD` if a 1 is clocked in on that same cycle.
- `ST_HUNT` goes to `ST_CMD` on a rising edge with data 1.
- `ST_CMD` goes to `ST_ARM` (external-clock mode) or `ST_HOLD` (any other mode) on the rising edge that captures the last mode bit.
- `ST_ARM` goes to `ST_STRB` on the next falling edge.
- `ST_STRB` goes to `ST_SHIFT` on the next falling edge.
- `ST_SHIFT` goes to `ST_HOLD` on the falling edge after the last result bit.

Top module: `sadc_cmd_slave`

## Requirements
- R1: While `cs_n` is high, `dout` and `sstrb` are 0 and the start-bit search and bit counters are cleared. After reset, `dout`, `sstrb`, `cmd_valid` and all command fields are 0.
- R2: After `cs_n` falls, any number of 0 bits clocked in on `din` have no effect; the first 1 is taken as command bit 7 (the start bit).
- R3: Command bits are captured on rising `sclk` edges while `cs_n` is low, MSB first. Bit 7 is the start bit, bits 6:4 the channel number, bit 3 polarity (1 unipolar, 0 bipolar), bit 2 input mode (1 single-ended, 0 differential), bits 1:0 the mode. The fields appear on `cmd_chan`, `cmd_unipolar`, `cmd_single`, `cmd_mode` one `clk` after the rising edge that captures bit 0, with `cmd_valid` high for exactly that one `clk` cycle. The fields hold until the next command.
- R4: `cmd_mode` encodes 00 full power-down, 01 fast power-down, 10 internal clock, 11 external clock. `int_clk_req` is 1 exactly while the held mode is 10.
- R5: In external-clock mode, the first falling `sclk` edge after bit 0 is captured raises `sstrb` for exactly one `sclk` period, with `dout` 0 during that period.
- R6: On the 12 following falling edges `dout` carries result bits 11 down to 0. It then stays 0 until `cs_n` rises, and further `din` bits in that frame start no new command.
- R7: `dout` and `sstrb` change only on a detected falling `sclk` edge or while `cs_n` is high. Rising edges never move them.
- R8: The sample of the selected channel is latched when bit 0 is captured; later changes on `samples` do not alter the bits being shifted out.
- R9: In unipolar mode the result is the sample as straight binary. In bipolar mode it is the sample minus 2048, modulo 4096, as two's complement (the sample MSB inverted).
- R10: For modes 00, 01 and 10, `sstrb` stays 0 and `dout` stays 0 for the rest of the frame, whatever is clocked in on `din`.
- R11: A rise of `cs_n` in the middle of a command abandons it. The next frame is decoded from its own start bit, and the abandoned bits leave the held fields unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; serial inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host, idle low |
| din | input | 1 | Serial command data |
| samples | input | NUM_CH*SAMPLE_W | Channel samples, channel k in bits [k*SAMPLE_W +: SAMPLE_W] |
| dout | output | 1 | Serial result data |
| sstrb | output | 1 | Strobe marking the period before the result MSB |
| cmd_valid | output | 1 | One-cycle pulse when a command has been decoded |
| cmd_chan | output | CH_W | Decoded channel number |
| cmd_unipolar | output | 1 | 1 unipolar, 0 bipolar |
| cmd_single | output | 1 | 1 single-ended, 0 differential |
| cmd_mode | output | 2 | Decoded power/clock mode |
| int_clk_req | output | 1 | Held mode is internal clock |

## Verification
The bench goes after leading zeros ahead of the start bit. A design that framed on the first clocked bit would decode a shifted command and select the wrong channel. It drives both polarity extremes with samples of 0x000 and 0xFFF: a missing or wrong offset conversion flips or drops the result MSB. It changes the sample bus halfway through a result, which a design that reads the bus live instead of latching it would follow. It also sends 1s after power-down, internal-clock and completed external-clock commands, and abandons a half-sent command with chip select. A design that re-armed the search would raise a stray strobe or corrupt the held fields.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_CMD,
        ST_ARM,
        ST_STRB,
        ST_SHIFT,
        ST_HOLD
    } sadc_state_e;

    typedef enum logic [1:0] {
        PM_FULL_PD = 2'b00,
        PM_FAST_PD = 2'b01,
        PM_INT_CLK = 2'b10,
        PM_EXT_CLK = 2'b11
    } sadc_pmode_e;

    typedef struct packed {
        logic [2:0]  chan;
        logic        unipolar;
        logic        single_end;
        sadc_pmode_e pmode;
    } sadc_cmd_t;

endpackage

// File: rtl/sadc_sclk_edges.sv
module sadc_sclk_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);

    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk;
        end
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;

endmodule

// File: rtl/sadc_sample_sel.sv
module sadc_sample_sel #(
    parameter int NUM_CH   = 8,
    parameter int SAMPLE_W = 12,
    parameter int CH_W     = $clog2(NUM_CH)
) (
    input  logic [NUM_CH*SAMPLE_W-1:0] samples,
    input  logic [CH_W-1:0]            chan,
    input  logic                       unipolar,
    output logic [SAMPLE_W-1:0]        code
);

    logic [SAMPLE_W-1:0] lanes [NUM_CH];
    logic [SAMPLE_W-1:0] raw;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
            assign lanes[g] = samples[g*SAMPLE_W +: SAMPLE_W];
        end
    endgenerate

    assign raw = lanes[chan];

    // offset binary to two's complement: inverting the MSB subtracts half scale
    assign code = unipolar ? raw : {~raw[SAMPLE_W-1], raw[SAMPLE_W-2:0]};

endmodule

// File: rtl/sadc_cmd_slave.sv
module sadc_cmd_slave
    import sadc_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int SAMPLE_W = 12,
    parameter int CH_W     = $clog2(NUM_CH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       sclk,
    input  logic                       din,
    input  logic [NUM_CH*SAMPLE_W-1:0] samples,
    output logic                       dout,
    output logic                       sstrb,
    output logic                       cmd_valid,
    output logic [CH_W-1:0]            cmd_chan,
    output logic                       cmd_unipolar,
    output logic                       cmd_single,
    output logic [1:0]                 cmd_mode,
    output logic                       int_clk_req
);

    localparam int CMD_W    = 8;
    localparam int BODY_W   = CMD_W - 1;
    localparam int HIST_W   = CMD_W - 2;
    localparam int BIT_CW   = $clog2(BODY_W);
    localparam int IDX_W    = $clog2(SAMPLE_W);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BODY_W - 1);
    localparam logic [IDX_W-1:0]  TOP_IDX  = IDX_W'(SAMPLE_W - 1);

    sadc_state_e          state_q, state_d;
    logic                 sclk_rise, sclk_fall;
    logic [HIST_W-1:0]    hist_q;
    logic [BIT_CW-1:0]    bit_cnt_q;
    logic [IDX_W-1:0]     idx_q;
    logic [SAMPLE_W-1:0]  result_q;
    logic [SAMPLE_W-1:0]  sel_code;
    logic [BODY_W-1:0]    body_word;
    sadc_cmd_t            decoded, cmd_q;
    logic                 start_seen;
    logic                 last_capture;

    sadc_sclk_edges u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    // the seven bits after the start bit, completed by the bit on din now
    assign body_word = {hist_q, din};
    assign decoded   = sadc_cmd_t'(body_word);

    sadc_sample_sel #(
        .NUM_CH   (NUM_CH),
        .SAMPLE_W (SAMPLE_W),
        .CH_W     (CH_W)
    ) u_sel (
        .samples  (samples),
        .chan     (decoded.chan[CH_W-1:0]),
        .unipolar (decoded.unipolar),
        .code     (sel_code)
    );

    assign start_seen   = (state_q == ST_IDLE || state_q == ST_HUNT) && sclk_rise && din;
    assign last_capture = (state_q == ST_CMD) && sclk_rise && (bit_cnt_q == LAST_BIT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = start_seen ? ST_CMD : ST_HUNT;
                ST_HUNT:  if (start_seen) state_d = ST_CMD;
                ST_CMD:   if (last_capture)
                              state_d = (decoded.pmode == PM_EXT_CLK) ? ST_ARM : ST_HOLD;
                ST_ARM:   if (sclk_fall) state_d = ST_STRB;
                ST_STRB:  if (sclk_fall) state_d = ST_SHIFT;
                ST_SHIFT: if (sclk_fall && idx_q == '0) state_d = ST_HOLD;
                ST_HOLD:  state_d = ST_HOLD;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // command capture, sample latch and result index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q    <= '0;
            bit_cnt_q <= '0;
            idx_q     <= '0;
            result_q  <= '0;
            cmd_q     <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (cs_n) begin
                hist_q    <= '0;
                bit_cnt_q <= '0;
                idx_q     <= '0;
            end else begin
                if (start_seen) begin
                    hist_q    <= '0;
                    bit_cnt_q <= '0;
                end else if (state_q == ST_CMD && sclk_rise) begin
                    hist_q    <= {hist_q[HIST_W-2:0], din};
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                    if (last_capture) begin
                        cmd_q     <= decoded;
                        cmd_valid <= 1'b1;
                        result_q  <= sel_code;
                    end
                end
                if (state_q == ST_STRB && sclk_fall) begin
                    idx_q <= TOP_IDX;
                end else if (state_q == ST_SHIFT && sclk_fall && idx_q != '0) begin
                    idx_q <= idx_q - 1'b1;
                end
            end
        end
    end

    // serial outputs, moved on falling serial-clock edges only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= 1'b0;
            sstrb <= 1'b0;
        end else if (cs_n) begin
            dout  <= 1'b0;
            sstrb <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ARM: begin
                    if (sclk_fall) begin
                        sstrb <= 1'b1;
                        dout  <= 1'b0;
                    end
                end
                ST_STRB: begin
                    if (sclk_fall) begin
                        sstrb <= 1'b0;
                        dout  <= result_q[SAMPLE_W-1];
                    end
                end
                ST_SHIFT: begin
                    if (sclk_fall) begin
                        dout <= (idx_q == '0) ? 1'b0 : result_q[idx_q - 1'b1];
                    end
                end
                default: begin
                    sstrb <= 1'b0;
                    dout  <= 1'b0;
                end
            endcase
        end
    end

    assign cmd_chan     = cmd_q.chan[CH_W-1:0];
    assign cmd_unipolar = cmd_q.unipolar;
    assign cmd_single   = cmd_q.single_end;
    assign cmd_mode     = cmd_q.pmode;
    assign int_clk_req  = (cmd_q.pmode == PM_INT_CLK);

endmodule

// File: rtl/sadc_cmd_slave_chk.sv
module sadc_cmd_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk_fall,
    input logic dout,
    input logic sstrb,
    input logic cmd_valid
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!dout && !sstrb)); // R1

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R3

    AST_STRB_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sstrb) |-> !dout); // R5

    AST_STRB_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sstrb && sclk_fall) |=> !sstrb); // R5

    AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dout) || !$stable(sstrb)) |-> $past(sclk_fall || cs_n)); // R7

endmodule

bind sadc_cmd_slave sadc_cmd_slave_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk_fall (sclk_fall),
    .dout      (dout),
    .sstrb     (sstrb),
    .cmd_valid (cmd_valid)
);

// File: tb/sadc_cmd_slave_tb.sv
module sadc_cmd_slave_tb_top;

    localparam int NCH = 8;
    localparam int SW  = 12;
    localparam int HOLD_CLKS = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cs_n = 1'b1;
    logic            sclk = 1'b0;
    logic            din = 1'b0;
    logic [SW-1:0]   smp [NCH];
    logic [NCH*SW-1:0] samples;
    logic            dout, sstrb, cmd_valid, cmd_unipolar, cmd_single, int_clk_req;
    logic [2:0]      cmd_chan;
    logic [1:0]      cmd_mode;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit          m_hunt = 0;
    bit          m_coll = 0;
    int          m_n = 0;
    logic [7:0]  m_word = '0;
    logic [1:0]  outq [$];
    logic        e_dout = 0, e_sstrb = 0, e_valid = 0, e_uni = 0, e_sgl = 0;
    logic [2:0]  e_chan = '0;
    logic [1:0]  e_mode = '0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) samples[i*SW +: SW] = smp[i];
    end

    sadc_cmd_slave dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .samples(samples), .dout(dout), .sstrb(sstrb), .cmd_valid(cmd_valid),
        .cmd_chan(cmd_chan), .cmd_unipolar(cmd_unipolar), .cmd_single(cmd_single),
        .cmd_mode(cmd_mode), .int_clk_req(int_clk_req)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("dout", dout, e_dout);
        chk("sstrb", sstrb, e_sstrb);
        chk("cmd_valid", cmd_valid, e_valid);
        chk("cmd_chan", cmd_chan, e_chan);
        chk("cmd_unipolar", cmd_unipolar, e_uni);
        chk("cmd_single", cmd_single, e_sgl);
        chk("cmd_mode", cmd_mode, e_mode);
        chk("int_clk_req", int_clk_req, (e_mode == 2'b10) ? 1 : 0);
        e_valid = 0;
    endtask

    task automatic settle();
        for (int k = 0; k < HOLD_CLKS; k++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic model_rise();
        logic [SW-1:0] v;
        if (m_hunt) begin
            if (din) begin
                m_hunt = 0; m_coll = 1; m_word = 8'h01; m_n = 1;
            end
        end else if (m_coll) begin
            m_word = {m_word[6:0], din};
            m_n++;
            if (m_n == 8) begin
                m_coll = 0;
                e_chan = m_word[6:4]; e_uni = m_word[3]; e_sgl = m_word[2];
                e_mode = m_word[1:0]; e_valid = 1;
                if (e_mode == 2'b11) begin
                    v = smp[e_chan];
                    if (!e_uni) v = SW'(int'(v) - 2048);
                    outq.push_back(2'b10);
                    for (int i = SW - 1; i >= 0; i--) outq.push_back({1'b0, v[i]});
                    outq.push_back(2'b00);
                end
            end
        end
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk);
        cs_n = v;
        if (v) begin
            outq.delete(); e_dout = 0; e_sstrb = 0; m_hunt = 0; m_coll = 0;
        end else begin
            m_hunt = 1;
        end
        settle();
    endtask

    task automatic clock_bit(input logic b);
        @(negedge clk);
        din = b;
        sclk = 1'b1;
        model_rise();
        settle();
        @(negedge clk);
        sclk = 1'b0;
        if (outq.size() > 0) {e_sstrb, e_dout} = outq.pop_front();
        settle();
    endtask

    task automatic frame(input int zeros, input logic [7:0] cmd, input int extra,
                         input logic extra_din, input string tag_cmd, input string tag_out,
                         input bit mutate);
        cur_req = tag_cmd;
        set_cs(1'b0);
        for (int i = 0; i < zeros; i++) clock_bit(1'b0);
        for (int i = 7; i >= 0; i--) clock_bit(cmd[i]);
        cur_req = tag_out;
        for (int i = 0; i < extra; i++) begin
            if (mutate && i == 3) begin
                for (int c = 0; c < NCH; c++) smp[c] = ~smp[c];
            end
            clock_bit(extra_din);
        end
        cur_req = "R1";
        set_cs(1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        smp[0] = 12'hFFF; smp[1] = 12'h3C7; smp[2] = 12'h123; smp[3] = 12'h6B1;
        smp[4] = 12'h801; smp[5] = 12'h000; smp[6] = 12'h7FF; smp[7] = 12'hA5C;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        compare_all();
        rst_n = 1'b1;
        settle();

        // ch7, unipolar, single-ended, external, after leading zeros
        frame(3, 8'hFF, 16, 1'b1, "R2", "R6", 0);
        // ch2, bipolar, differential, external
        frame(0, 8'hA3, 16, 1'b0, "R3", "R9", 0);
        // ch0 full-scale unipolar, external
        frame(1, 8'h8F, 16, 1'b0, "R4", "R7", 0);
        // ch5 zero sample in bipolar mode
        frame(2, 8'hD7, 16, 1'b1, "R3", "R9", 0);
        // ch6 external, strobe timing
        frame(0, 8'hEF, 16, 1'b0, "R5", "R5", 0);
        // internal clock, full and fast power-down: no serial result
        frame(0, 8'hBE, 16, 1'b1, "R4", "R10", 0);
        frame(1, 8'hC8, 16, 1'b1, "R4", "R10", 0);
        frame(0, 8'h95, 16, 1'b1, "R4", "R10", 0);
        // sample bus changes while the result shifts out
        frame(0, 8'hBF, 16, 1'b0, "R8", "R8", 1);

        // abandoned half command, then a fresh frame
        cur_req = "R11";
        set_cs(1'b0);
        clock_bit(1'b0); clock_bit(1'b1); clock_bit(1'b1); clock_bit(1'b0);
        set_cs(1'b1);
        frame(0, 8'h9F, 16, 1'b0, "R11", "R11", 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule